// File: doc/BRIEF.md
# Three-Wire Serial ADC Read Controller

This block is the master side of a three-wire link to a 12-bit sampling converter whose command and result share one bidirectional data wire. A start request opens a frame by pulling chip select low. The block then clocks out a four-bit request word and, at a fixed clock edge partway through the frame, stops driving the data wire so that the converter can take it over. It then clocks in a leading null bit and the twelve result bits, most significant first. When the frame ends the block raises chip select, places the result on its output and strobes a done flag for one cycle.

The serial clock is derived from the system clock by a parameterised divider. Each half period of the serial clock lasts `HALF_DIV` system cycles, and `HALF_DIV` must be at least 2. The data pad is not part of the block. It exposes a driven value, a registered output enable and the pad input, and the pad ring builds the tri-state buffer from these.

Control is plain rather than a stream. A start pulse is taken only while `busy_o` is low. The result path has no back-pressure: `result_o` and `null_err_o` keep their values until the next frame completes, and `done_o` marks the cycle in which they change.

Top module: `adcrd_ctrl`

## Requirements
- R1: After synchronous reset the outputs are in the idle state: `cs_n_o`=1, `sclk_o`=0, `dio_oe_o`=0, `busy_o`=0 and `done_o`=0. While `cs_n_o` is high, `sclk_o` stays 0 and `dio_oe_o` stays 0.
- R2: If `start_i` is high at a clock edge while the block is idle, then after that edge `cs_n_o` is 0, `busy_o` is 1 and `dio_oe_o` is 1.
- R3: Within a frame `sclk_o` starts low and toggles every `HALF_DIV` system cycles, so rising edges are 2*`HALF_DIV` cycles apart. A frame has exactly 17 rising edges.
- R4: The four values of `dio_out_o` seen at rising edges 1 to 4 are, in order: 1, `cfg_single_i`, `cfg_odd_i`, 1. The last 1 requests most-significant-first output. The configuration inputs are latched when the start is accepted, and `dio_out_o` changes only on falling edges.
- R5: `dio_oe_o` rises together with the fall of `cs_n_o` and stays high through the 4th rising edge. It falls one system cycle after that edge, while `sclk_o` is still high, so it is low before the 4th falling edge.
- R6: `dio_in_i` is sampled in the system cycle just before each of falling edges 5 to 17, and only while the line is released. The first sample is the null bit; the next twelve are result bits 11 down to 0.
- R7: At the edge after the 17th falling edge, `cs_n_o` rises and `done_o` pulses high for exactly one cycle. In that cycle `result_o` holds the twelve captured bits, and it keeps that value until the next frame completes. `busy_o` is low from then on.
- R8: `null_err_o` is updated at each completed frame and is 1 exactly when the captured null bit was 1.
- R9: A start request made while `busy_o` is high is ignored. The running frame, its request word and the number of done pulses are unchanged.
- R10: A synchronous reset in the middle of a frame returns the outputs to the idle state of R1 at the next edge, and a later start runs a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request one conversion read |
| cfg_single_i | input | 1 | Single-ended (1) or differential (0) request bit |
| cfg_odd_i | input | 1 | Odd/sign channel select request bit |
| busy_o | output | 1 | Frame in progress |
| result_o | output | RES_BITS | Last conversion result |
| done_o | output | 1 | One-cycle strobe, result updated |
| null_err_o | output | 1 | Captured null bit was not 0 |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| dio_out_o | output | 1 | Value driven onto the shared data wire |
| dio_oe_o | output | 1 | Drive enable for the shared data wire |
| dio_in_i | input | 1 | Value read from the shared data wire |

## Verification
The assertions check these rules on every cycle:
- the idle levels of clock and drive enable while chip select is high;
- that the drive enable is claimed only as chip select falls and released only while the serial clock is high;
- that sampling happens only with the serial clock high and the line released;
- that the done strobe lasts one cycle and coincides with chip select rising.

Other properties only the bench's scenarios can show. These are the exact request bits and their order, the count of 17 clock edges and their spacing, the mapping of sampled bits onto the result, the null-bit error flag, the rejection of a start during a frame and recovery from a reset in mid-frame. For these the bench uses a converter model that takes the wire at the 4th falling edge and flags any overlap of the two drivers.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  // Width of the request word sent at the head of every frame.
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_XFER  = 2'd1,
    SEQ_CLOSE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic single;
    logic odd;
  } req_cfg_t;

  // Request word, first bit in the MSB: start marker, mode bits, MSB-first request.
  function automatic logic [CMD_W-1:0] make_cmd(input req_cfg_t cfg);
    return {1'b1, cfg.single, cfg.odd, 1'b1};
  endfunction

endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_evt_o,
  output logic fall_evt_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Events mark the cycle whose closing edge flips the serial clock.
  assign rise_evt_o = wrap && !sclk_o;
  assign fall_evt_o = wrap && sclk_o;

  initial begin
    if (HALF_DIV < 2) $error("adcrd_sclk_gen: HALF_DIV must be at least 2");
  end

endmodule

// File: rtl/adcrd_frame_seq.sv
module adcrd_frame_seq
  import adcrd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  req_cfg_t cfg_i,
  input  logic     rise_evt_i,
  input  logic     fall_evt_i,
  output logic     run_o,
  output logic     busy_o,
  output logic     cs_n_o,
  output logic     dout_o,
  output logic     oe_o,
  output logic     sample_o,
  output logic     finish_o
);

  // Falling edges per frame: request bits, null bit, result bits.
  localparam int LAST_FALL = CMD_W + 1 + RES_BITS;
  localparam int FCW       = $clog2(LAST_FALL + 1);
  localparam logic [FCW-1:0] TURN_CNT = FCW'(CMD_W - 1);
  localparam logic [FCW-1:0] RX_FIRST = FCW'(CMD_W);
  localparam logic [FCW-1:0] END_CNT  = FCW'(LAST_FALL - 1);

  seq_state_t       state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [FCW-1:0]   fall_cnt_q;
  logic             drop_pend_q;
  logic [CMD_W-1:0] cmd_new;

  assign cmd_new = make_cmd(cfg_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      cs_n_o      <= 1'b1;
      oe_o        <= 1'b0;
      dout_o      <= 1'b0;
      cmd_q       <= '0;
      fall_cnt_q  <= '0;
      drop_pend_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q     <= SEQ_XFER;
            cs_n_o      <= 1'b0;
            oe_o        <= 1'b1;
            dout_o      <= cmd_new[CMD_W-1];
            cmd_q       <= cmd_new;
            fall_cnt_q  <= '0;
            drop_pend_q <= 1'b0;
          end
        end
        SEQ_XFER: begin
          if (drop_pend_q) begin
            oe_o        <= 1'b0;
            drop_pend_q <= 1'b0;
          end
          if (rise_evt_i && fall_cnt_q == TURN_CNT) drop_pend_q <= 1'b1;
          if (fall_evt_i) begin
            fall_cnt_q <= fall_cnt_q + 1'b1;
            dout_o     <= cmd_q[CMD_W-2];
            cmd_q      <= {cmd_q[CMD_W-2:0], 1'b0};
            if (fall_cnt_q == END_CNT) state_q <= SEQ_CLOSE;
          end
        end
        SEQ_CLOSE: begin
          cs_n_o  <= 1'b1;
          state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q == SEQ_XFER);
  assign busy_o   = (state_q != SEQ_IDLE);
  assign finish_o = (state_q == SEQ_CLOSE);
  assign sample_o = fall_evt_i && (state_q == SEQ_XFER) && (fall_cnt_q >= RX_FIRST);

  // R6
  rx_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> !oe_o);

endmodule

// File: rtl/adcrd_rx_capture.sv
module adcrd_rx_capture #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_i,
  input  logic                din_i,
  input  logic                finish_i,
  output logic [RES_BITS-1:0] result_o,
  output logic                null_err_o,
  output logic                done_o
);

  // One slot for the null bit above the result bits.
  localparam int SW = RES_BITS + 1;

  logic [SW-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= '0;
      result_o   <= '0;
      null_err_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (sample_i) shift_q <= {shift_q[SW-2:0], din_i};
      if (finish_i) begin
        result_o   <= shift_q[RES_BITS-1:0];
        null_err_o <= shift_q[RES_BITS];
      end
    end
  end

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cfg_single_i,
  input  logic                cfg_odd_i,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o,
  output logic                null_err_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                dio_out_o,
  output logic                dio_oe_o,
  input  logic                dio_in_i
);

  logic     run, rise_evt, fall_evt, sample, finish;
  req_cfg_t cfg;

  assign cfg.single = cfg_single_i;
  assign cfg.odd    = cfg_odd_i;

  adcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk(clk), .rst(rst), .run_i(run),
    .sclk_o(sclk_o), .rise_evt_o(rise_evt), .fall_evt_o(fall_evt)
  );

  adcrd_frame_seq #(.RES_BITS(RES_BITS)) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg),
    .rise_evt_i(rise_evt), .fall_evt_i(fall_evt),
    .run_o(run), .busy_o(busy_o), .cs_n_o(cs_n_o),
    .dout_o(dio_out_o), .oe_o(dio_oe_o),
    .sample_o(sample), .finish_o(finish)
  );

  adcrd_rx_capture #(.RES_BITS(RES_BITS)) rx_i (
    .clk(clk), .rst(rst), .sample_i(sample), .din_i(dio_in_i),
    .finish_i(finish), .result_o(result_o),
    .null_err_o(null_err_o), .done_o(done_o)
  );

  // R1
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R1
  idle_line_free_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !dio_oe_o);

  // R5
  oe_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dio_oe_o) |-> $fell(cs_n_o));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dio_oe_o) |-> (sclk_o && !cs_n_o));

  // R6
  sample_high_chk: assert property (@(posedge clk) disable iff (rst)
    sample |-> sclk_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o));

endmodule

// File: tb/adcrd_ctrl_tb.sv
module adcrd_ctrl_tb_top;

  localparam int HALF = 4;
  localparam int RB   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, cfg_single_i = 1'b0, cfg_odd_i = 1'b0;
  logic busy_o, done_o, null_err_o, cs_n_o, sclk_o, dio_out_o, dio_oe_o, dio_in_i;
  logic [RB-1:0] result_o;

  always #10 clk = ~clk;

  // Converter model state
  logic [RB-1:0] m_val = '0;
  logic          m_null = 1'b0;
  logic          drv = 1'b0, adc_bit = 1'b1;
  logic          prev_sclk = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;
  int            rcnt = 0, fcnt = 0, since_rise = 0, per_min = 0, per_max = 0;
  logic [3:0]    cmd_seen = '0;
  logic          oe_r4 = 1'b0, oe_f4 = 1'b1, clash = 1'b0, wide = 1'b0;
  int            done_cnt = 0;
  logic [RB-1:0] cap_res = '0;
  logic          cap_err = 1'b0, cap_cs = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 0;

  assign dio_in_i = drv ? adc_bit : 1'b1;

  adcrd_ctrl #(.HALF_DIV(HALF), .RES_BITS(RB)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cfg_single_i(cfg_single_i), .cfg_odd_i(cfg_odd_i),
    .busy_o(busy_o), .result_o(result_o), .done_o(done_o),
    .null_err_o(null_err_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .dio_out_o(dio_out_o), .dio_oe_o(dio_oe_o), .dio_in_i(dio_in_i)
  );

  always @(negedge clk) begin
    if (prev_cs && !cs_n_o) begin
      rcnt = 0; fcnt = 0; drv = 1'b0; cmd_seen = '0; since_rise = 0;
      per_min = 9999; per_max = 0; oe_r4 = 1'b0; oe_f4 = 1'b1;
    end
    if (!cs_n_o) begin
      since_rise++;
      if (!prev_sclk && sclk_o) begin
        rcnt++;
        if (rcnt > 1) begin
          if (since_rise < per_min) per_min = since_rise;
          if (since_rise > per_max) per_max = since_rise;
        end
        since_rise = 0;
        if (rcnt <= 4) cmd_seen = {cmd_seen[2:0], dio_out_o};
        if (rcnt == 4) oe_r4 = dio_oe_o;
      end
      if (prev_sclk && !sclk_o) begin
        fcnt++;
        if (fcnt == 4) begin
          oe_f4 = dio_oe_o; drv = 1'b1; adc_bit = m_null;
        end else if (fcnt >= 5 && fcnt <= 16) begin
          adc_bit = m_val[16-fcnt];
        end
      end
    end else begin
      drv = 1'b0;
    end
    if (drv && dio_oe_o) clash = 1'b1;
    if (done_o) begin
      done_cnt++;
      cap_res = result_o; cap_err = null_err_o; cap_cs = cs_n_o;
      if (prev_done) wide = 1'b1;
    end
    prev_sclk = sclk_o; prev_cs = cs_n_o; prev_done = done_o;
  end

  function automatic logic [3:0] exp_cmd(input logic s, input logic o);
    return {1'b1, s, o, 1'b1};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_checks(input string tag);
    chk({tag, " cs_n high"}, int'(cs_n_o), 1);
    chk({tag, " sclk low"}, int'(sclk_o), 0);
    chk({tag, " oe low"}, int'(dio_oe_o), 0);
    chk({tag, " busy low"}, int'(busy_o), 0);
    chk({tag, " done low"}, int'(done_o), 0);
  endtask

  task automatic run_frame(input logic [RB-1:0] v, input logic s, input logic o,
                           input logic nb, input bit poke);
    int waited;
    m_val = v; m_null = nb; done_cnt = 0; clash = 1'b0; wide = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cfg_single_i = s; cfg_odd_i = o;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 cs_n low after start", int'(cs_n_o), 0);
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 oe after start", int'(dio_oe_o), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R9 busy mid-frame", int'(busy_o), 1);
      start_i = 1'b1; cfg_single_i = ~s; cfg_odd_i = ~o;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 2000) begin
      @(negedge clk); waited++;
    end
    repeat (6) @(negedge clk);
    chk("R4 request word", int'(cmd_seen), int'(exp_cmd(s, o)));
    chk("R5 oe high at rise 4", int'(oe_r4), 1);
    chk("R5 oe low at fall 4", int'(oe_f4), 0);
    chk("R5 no bus clash", int'(clash), 0);
    chk("R3 rising edge count", rcnt, 17);
    chk("R3 min period", per_min, 2*HALF);
    chk("R3 max period", per_max, 2*HALF);
    chk("R6 result bits", int'(cap_res), int'(v));
    chk("R8 null error flag", int'(cap_err), int'(nb));
    chk("R7 single done", done_cnt, 1);
    chk("R7 done one cycle", int'(wide), 0);
    chk("R7 cs_n high with done", int'(cap_cs), 1);
    chk("R7 result held", int'(result_o), int'(v));
    chk("R7 busy low after", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5eed_0c1a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("R1 reset");

    // Directed corner values
    run_frame(12'h000, 1'b1, 1'b0, 1'b0, 0);
    run_frame(12'hFFF, 1'b0, 1'b1, 1'b0, 0);
    run_frame(12'hA5A, 1'b1, 1'b1, 1'b1, 0);
    run_frame(12'h801, 1'b0, 1'b0, 1'b0, 1);

    // Reset in the middle of a frame
    m_val = 12'h3C3; m_null = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cfg_single_i = 1'b1; cfg_odd_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (70) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    idle_checks("R10 mid-frame reset");
    rst = 1'b0;
    @(negedge clk);
    run_frame(12'h3C3, 1'b0, 1'b1, 1'b0, 0);

    // Random frames
    for (int i = 0; i < 30; i++) begin
      r = $urandom;
      run_frame(r[11:0], r[12], r[13], (r[16:14] == 3'b000), r[20:18] == 3'b111);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule